// File: doc/BRIEF.md
# Prioritized Eight-Line Interrupt Controller

This block collects eight interrupt request lines and presents the most urgent unmasked one to a processor on a single interrupt output. When the processor acknowledges, the block returns an 8-bit vector in the same cycle. It also records the line as in service, so lower-priority lines stay blocked until software ends that service. Software programs the block through two byte-wide addresses. The command address carries the start of the initialization word sequence, end-of-service commands and the choice of status register. The data address carries the remaining initialization words and, after that, the mask.

Two instances can be chained. A master lists, in a one-hot map, the inputs that have a subordinate controller attached. When one of those inputs is acknowledged, the master names the input on its cascade outputs and does not drive a vector. The subordinate whose programmed identity matches that input then supplies the vector. Priority is fixed, with line 0 the highest. Requests are taken on rising edges, and the line must still be high when it is acknowledged. An automatic end-of-service mode and spurious-interrupt reporting on line 7 are supported.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask is 0xFF, IRR and ISR read 0, and int_out stays low until an initialization sequence completes, whatever the request lines do.
- R2: A command write with bit 4 set (0x11 in normal use) starts initialization. It clears IRR, ISR, the mask and the cascade map, and it selects IRR for status reads. The next data writes are taken in this order: the vector base; the cascade word, unless bit 1 of the start word was set; the mode word, only if bit 0 of the start word was set. Initialization then ends.
- R3: Once initialized, a data-address write loads the mask. A 1 in bit n masks line n. A data-address read returns the mask.
- R4: IRR bit n is set on a rising edge of line n. It clears when line n is low at a clock edge, when line n is acknowledged, or on a new initialization. Masked lines still set IRR.
- R5: int_out is high when some unmasked IRR bit has a lower index than every set ISR bit. Line 0 has the highest priority.
- R6: An acknowledge that finds a valid request returns the vector base plus the winning line number, clears that IRR bit and sets that ISR bit.
- R7: Command write 0x60+n clears ISR bit n. Command write 0x20 clears the lowest-indexed set ISR bit.
- R8: Command write 0x0B makes command-address reads return ISR. Command write 0x0A returns them to IRR.
- R9: When bit 1 of the mode word is set, an acknowledge clears the IRR bit and sets no ISR bit.
- R10: An acknowledge with no valid request returns the vector base plus 7 and leaves ISR unchanged. This happens even when line 7 is masked.
- R11: On a master, acknowledging a line whose bit is set in the cascade map drives cas_sel_out high and cas_id_out to the line number, and keeps vec_en low. A subordinate whose cascade word, bits 2:0, equals cas_id_in while cas_sel_in is high answers that acknowledge with its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: master role, 0: subordinate role |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0: command address, 1: data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (IRR/ISR or mask) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor or master |
| inta | input | 1 | One-cycle acknowledge |
| cas_sel_in | input | 1 | Cascade select from a master |
| cas_id_in | input | 3 | Master line being acknowledged |
| cas_sel_out | output | 1 | This master acknowledges a cascaded line |
| cas_id_out | output | 3 | Line number of that cascaded acknowledge |
| vec_en | output | 1 | This unit drives vec_out in the acknowledge cycle |
| vec_out | output | 8 | Interrupt vector |

## Verification
The bench wires a master and a subordinate together on line 2. It concentrates on the nested cases. While a subordinate line is in service, a new and more urgent subordinate request must stay blocked at the master until both end-of-service commands arrive, subordinate first. A design that ignored ISR in arbitration would instead re-interrupt at once with the wrong vector. It also checks the spurious case, where a request drops before acknowledge: a faulty design would return the stale line's vector or leave an ISR bit stuck. The automatic end-of-service mode is checked the same way. Other checks cover the shortened initialization sequences, where a mis-sequenced design would load the base or the mask into the wrong register. Random masks and request patterns then confirm that the lowest unmasked line always wins.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDW   = $clog2(LINES);
  localparam int unsigned DW    = 8;

  // command decode positions
  localparam int unsigned INIT_BIT   = 4;
  localparam int unsigned SNGL_BIT   = 1;
  localparam int unsigned WANT4_BIT  = 0;
  localparam int unsigned AEOI_BIT   = 1;
  localparam int unsigned RSEL_V_BIT = 1;
  localparam int unsigned RSEL_S_BIT = 0;
  localparam logic [2:0]  EOI_SPEC   = 3'b011;
  localparam logic [2:0]  EOI_LOW    = 3'b001;
  localparam logic [1:0]  GRP_OCW2   = 2'b00;
  localparam logic [1:0]  GRP_OCW3   = 2'b01;
  localparam logic [DW-1:0] MASK_RST = '1;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE
  } seq_t;
endpackage

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc_cfg.sv
module prio_intc_cfg
  import prio_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr_dat,
  input  logic [DW-1:0]    wdata,
  output logic [LINES-1:0] mask,
  output logic [DW-1:0]    base,
  output logic [DW-1:0]    casc,
  output logic             auto_eoi,
  output logic             ready,
  output logic             sel_isr,
  output logic             init_pulse,
  output logic             eoi_spec,
  output logic             eoi_low,
  output logic [IDW-1:0]   eoi_line
);
  logic cmd_wr, dat_wr, ocw2_wr, ocw3_wr;

  seq_t             seq_q, seq_nx;
  logic             skip_q, skip_nx;
  logic             want4_q, want4_nx;
  logic             ready_q, ready_nx;
  logic             aeoi_q, aeoi_nx;
  logic             sel_q, sel_nx;
  logic [LINES-1:0] mask_q, mask_nx;
  logic             mask_en;
  logic [DW-1:0]    base_q;
  logic             base_en;
  logic [DW-1:0]    casc_q, casc_nx;
  logic             casc_en;

  assign cmd_wr     = wr_en & ~addr_dat;
  assign dat_wr     = wr_en & addr_dat;
  assign init_pulse = cmd_wr & wdata[INIT_BIT];
  assign ocw2_wr    = cmd_wr & (wdata[4:3] == GRP_OCW2);
  assign ocw3_wr    = cmd_wr & (wdata[4:3] == GRP_OCW3);
  assign eoi_spec   = ocw2_wr & (wdata[7:5] == EOI_SPEC);
  assign eoi_low    = ocw2_wr & (wdata[7:5] == EOI_LOW);
  assign eoi_line   = wdata[IDW-1:0];

  always_comb begin
    seq_nx   = seq_q;
    skip_nx  = skip_q;
    want4_nx = want4_q;
    ready_nx = ready_q;
    aeoi_nx  = aeoi_q;
    sel_nx   = sel_q;
    mask_en  = 1'b0;
    mask_nx  = mask_q;
    base_en  = 1'b0;
    casc_en  = 1'b0;
    casc_nx  = casc_q;
    if (init_pulse) begin
      seq_nx   = SEQ_BASE;
      skip_nx  = wdata[SNGL_BIT];
      want4_nx = wdata[WANT4_BIT];
      ready_nx = 1'b0;
      aeoi_nx  = 1'b0;
      sel_nx   = 1'b0;
      mask_en  = 1'b1;
      mask_nx  = '0;
      casc_en  = 1'b1;
      casc_nx  = '0;
    end else if (dat_wr) begin
      unique case (seq_q)
        SEQ_BASE: begin
          base_en = 1'b1;
          if (!skip_q) begin
            seq_nx = SEQ_CASC;
          end else if (want4_q) begin
            seq_nx = SEQ_MODE;
          end else begin
            seq_nx   = SEQ_IDLE;
            ready_nx = 1'b1;
          end
        end
        SEQ_CASC: begin
          casc_en = 1'b1;
          casc_nx = wdata;
          if (want4_q) begin
            seq_nx = SEQ_MODE;
          end else begin
            seq_nx   = SEQ_IDLE;
            ready_nx = 1'b1;
          end
        end
        SEQ_MODE: begin
          aeoi_nx  = wdata[AEOI_BIT];
          seq_nx   = SEQ_IDLE;
          ready_nx = 1'b1;
        end
        default: begin
          mask_en = 1'b1;
          mask_nx = wdata[LINES-1:0];
        end
      endcase
    end else if (ocw3_wr && wdata[RSEL_V_BIT]) begin
      sel_nx = wdata[RSEL_S_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SEQ_IDLE;
      skip_q  <= 1'b0;
      want4_q <= 1'b0;
      ready_q <= 1'b0;
      aeoi_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      seq_q   <= seq_nx;
      skip_q  <= skip_nx;
      want4_q <= want4_nx;
      ready_q <= ready_nx;
      aeoi_q  <= aeoi_nx;
      sel_q   <= sel_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST[LINES-1:0];
    end else if (mask_en) begin
      mask_q <= mask_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q <= '0;
    end else if (casc_en) begin
      casc_q <= casc_nx;
    end
  end

  assign mask     = mask_q;
  assign base     = base_q;
  assign casc     = casc_q;
  assign auto_eoi = aeoi_q;
  assign ready    = ready_q;
  assign sel_isr  = sel_q;
endmodule

// File: rtl/prio_intc_core.sv
module prio_intc_core
  import prio_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic [LINES-1:0] mask,
  input  logic             ready,
  input  logic             init_clr,
  input  logic             auto_eoi,
  input  logic             eoi_spec,
  input  logic             eoi_low,
  input  logic [IDW-1:0]   eoi_line,
  input  logic             ack,
  output logic [LINES-1:0] irr,
  output logic [LINES-1:0] isr,
  output logic             int_req,
  output logic             ack_ok,
  output logic [IDW-1:0]   win_line
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] irr_q, irr_nx;
  logic [LINES-1:0] isr_q, isr_nx;
  logic             req_found, isr_found;
  logic [IDW-1:0]   req_idx, isr_idx;

  prio_intc_pick #(.W(LINES)) u_pick_req (
    .vec   (irr_q & ~mask),
    .found (req_found),
    .idx   (req_idx)
  );

  prio_intc_pick #(.W(LINES)) u_pick_isr (
    .vec   (isr_q),
    .found (isr_found),
    .idx   (isr_idx)
  );

  assign int_req  = ready & req_found & (~isr_found | (req_idx < isr_idx));
  assign ack_ok   = ack & int_req;
  assign win_line = req_idx;

  always_comb begin
    irr_nx = (irr_q | (req_in & ~prev_q)) & req_in;
    if (ack_ok) irr_nx[req_idx] = 1'b0;
    if (init_clr) irr_nx = '0;
  end

  always_comb begin
    isr_nx = isr_q;
    if (ack_ok && !auto_eoi) isr_nx[req_idx] = 1'b1;
    if (eoi_spec) isr_nx[eoi_line] = 1'b0;
    if (eoi_low && isr_found) isr_nx[isr_idx] = 1'b0;
    if (init_clr) isr_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= req_in;
      irr_q  <= irr_nx;
      isr_q  <= isr_nx;
    end
  end

  assign irr = irr_q;
  assign isr = isr_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LINES-1:0] irq_in,
  output logic             int_out,
  input  logic             inta,
  input  logic             cas_sel_in,
  input  logic [IDW-1:0]   cas_id_in,
  output logic             cas_sel_out,
  output logic [IDW-1:0]   cas_id_out,
  output logic             vec_en,
  output logic [DW-1:0]    vec_out
);
  localparam logic [IDW-1:0] SPUR_LINE = IDW'(LINES - 1);

  logic [LINES-1:0] mask, irr, isr;
  logic [DW-1:0]    base, casc;
  logic             auto_eoi, ready, sel_isr, init_pulse;
  logic             eoi_spec, eoi_low;
  logic [IDW-1:0]   eoi_line;
  logic             ack_here, ack_ok, int_req, to_sub;
  logic [IDW-1:0]   win_line, vec_line;

  prio_intc_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr_dat   (bus_addr),
    .wdata      (bus_wdata),
    .mask       (mask),
    .base       (base),
    .casc       (casc),
    .auto_eoi   (auto_eoi),
    .ready      (ready),
    .sel_isr    (sel_isr),
    .init_pulse (init_pulse),
    .eoi_spec   (eoi_spec),
    .eoi_low    (eoi_low),
    .eoi_line   (eoi_line)
  );

  assign ack_here = inta & (master_mode | (cas_sel_in & (cas_id_in == casc[IDW-1:0])));

  prio_intc_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (irq_in),
    .mask     (mask),
    .ready    (ready),
    .init_clr (init_pulse),
    .auto_eoi (auto_eoi),
    .eoi_spec (eoi_spec),
    .eoi_low  (eoi_low),
    .eoi_line (eoi_line),
    .ack      (ack_here),
    .irr      (irr),
    .isr      (isr),
    .int_req  (int_req),
    .ack_ok   (ack_ok),
    .win_line (win_line)
  );

  assign to_sub      = master_mode & ack_ok & casc[win_line];
  assign vec_line    = ack_ok ? win_line : SPUR_LINE;
  assign cas_sel_out = ack_here & to_sub;
  assign cas_id_out  = win_line;
  assign vec_en      = ack_here & ~to_sub;
  assign vec_out     = base + DW'(vec_line);
  assign int_out     = int_req;
  assign bus_rdata   = bus_addr ? DW'(mask) : (sel_isr ? DW'(isr) : DW'(irr));
endmodule

// File: rtl/prio_intc_sva.sv
module prio_intc_sva
  import prio_intc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] irq_in,
  input logic             int_out,
  input logic             ready,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] irr,
  input logic [LINES-1:0] isr,
  input logic             ack_here,
  input logic             ack_ok,
  input logic [IDW-1:0]   win_line,
  input logic             auto_eoi,
  input logic             eoi_spec,
  input logic             eoi_low,
  input logic [IDW-1:0]   eoi_line,
  input logic             init_pulse
);
  a_r1_int_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ready);

  a_r5_int_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !auto_eoi && !eoi_spec && !eoi_low && !init_pulse) |=> isr[$past(win_line)]);

  a_r7_spec_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_spec && !ack_ok) |=> !isr[$past(eoi_line)]);

  a_r9_auto_eoi_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_here && auto_eoi && !eoi_spec && !eoi_low && !init_pulse) |=> $stable(isr));

  a_r10_spurious_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_here && !ack_ok && !eoi_spec && !eoi_low && !init_pulse) |=> $stable(isr));

  for (genvar g = 0; g < LINES; g++) begin : g_lvl
    a_r4_low_line_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[g] |=> !irr[g]);
  end
endmodule

bind prio_intc prio_intc_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .int_out    (int_out),
  .ready      (ready),
  .mask       (mask),
  .irr        (irr),
  .isr        (isr),
  .ack_here   (ack_here),
  .ack_ok     (ack_ok),
  .win_line   (win_line),
  .auto_eoi   (auto_eoi),
  .eoi_spec   (eoi_spec),
  .eoi_low    (eoi_low),
  .eoi_line   (eoi_line),
  .init_pulse (init_pulse)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, m_wr, s_wr, bus_addr, inta;
  logic [7:0] bus_wdata, m_rdata, s_rdata, m_lines, s_irq, m_irq;
  logic       m_int, s_int, m_cas_sel, s_cas_sel, m_vec_en, s_vec_en;
  logic [2:0] m_cas_id, s_cas_id;
  logic [7:0] m_vec, s_vec;
  int nchk = 0, nfail = 0;
  bit done = 0;

  assign m_irq = {m_lines[7:3], s_int, m_lines[1:0]};

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(1'b1), .bus_wr(m_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(m_rdata), .irq_in(m_irq), .int_out(m_int),
    .inta(inta), .cas_sel_in(1'b0), .cas_id_in(3'd0), .cas_sel_out(m_cas_sel),
    .cas_id_out(m_cas_id), .vec_en(m_vec_en), .vec_out(m_vec));

  prio_intc u_slave (
    .clk(clk), .rst_n(rst_n), .master_mode(1'b0), .bus_wr(s_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .irq_in(s_irq), .int_out(s_int),
    .inta(inta), .cas_sel_in(m_cas_sel), .cas_id_in(m_cas_id), .cas_sel_out(s_cas_sel),
    .cas_id_out(s_cas_id), .vec_en(s_vec_en), .vec_out(s_vec));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit sub, input bit a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d;
    if (sub) s_wr = 1'b1; else m_wr = 1'b1;
    tick();
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic rd(input bit sub, input bit a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = sub ? s_rdata : m_rdata;
  endtask

  task automatic ack(output logic [7:0] v, output bit one_src);
    inta = 1'b1;
    #1;
    one_src = m_vec_en ^ s_vec_en;
    v = m_vec_en ? m_vec : s_vec;
    tick();
    inta = 1'b0;
  endtask

  function automatic int lowest(input logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d, v, msk, pat, exp_req;
    bit one;
    void'($urandom(32'd4242));
    rst_n = 1'b0; m_wr = 0; s_wr = 0; bus_addr = 0; bus_wdata = 0; inta = 0;
    m_lines = 0; s_irq = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(0, 1, d); chk("R1 mask after reset", d, 8'hFF);
    rd(0, 0, d); chk("R1 irr after reset", d, 8'h00);
    chk("R1 int low after reset", m_int, 0);
    m_lines[0] = 1'b1; tick(); tick();
    chk("R1 no int before init", m_int, 0);
    m_lines = 0; tick();

    // R2 init both units
    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    rd(0, 1, d); chk("R2 init clears mask", d, 8'h00);
    wr(1, 1, 8'hFF);
    wr(0, 1, 8'hFF);
    rd(0, 1, d); chk("R3 mask readback", d, 8'hFF);

    // R8/R4/R3 masked line in IRR
    m_lines[6] = 1'b1; tick();
    rd(0, 0, d); chk("R4 masked edge sets irr", d, 8'h40);
    chk("R3 masked line no int", m_int, 0);
    wr(0, 0, 8'h0B); rd(0, 0, d); chk("R8 isr select", d, 8'h00);
    wr(0, 0, 8'h0A); rd(0, 0, d); chk("R8 irr select", d, 8'h40);
    m_lines = 0; tick();
    rd(0, 0, d); chk("R4 low line clears irr", d, 8'h00);

    // R5/R6/R7 nested priorities
    wr(0, 1, 8'h00);
    m_lines[4] = 1'b1; tick();
    chk("R5 int on IR4", m_int, 1);
    ack(v, one); chk("R6 vector IR4", v, 8'h24); chk("R6 single source", one, 1);
    rd(0, 0, d); chk("R6 irr cleared by ack", d, 8'h00);
    wr(0, 0, 8'h0B); rd(0, 0, d); chk("R6 isr IR4", d, 8'h10);
    m_lines[5] = 1'b1; tick();
    chk("R5 lower line blocked", m_int, 0);
    m_lines[1] = 1'b1; tick();
    chk("R5 higher line preempts", m_int, 1);
    ack(v, one); chk("R6 vector IR1", v, 8'h21);
    rd(0, 0, d); chk("R6 nested isr", d, 8'h12);
    wr(0, 0, 8'h20); rd(0, 0, d); chk("R7 nonspecific eoi", d, 8'h10);
    chk("R5 still blocked", m_int, 0);
    wr(0, 0, 8'h64); rd(0, 0, d); chk("R7 specific eoi", d, 8'h00);
    chk("R5 pending IR5 raises", m_int, 1);
    ack(v, one); chk("R6 vector IR5", v, 8'h25);
    wr(0, 0, 8'h65);
    m_lines = 0; tick();

    // R10 spurious
    wr(0, 1, 8'h80);
    m_lines[3] = 1'b1; tick();
    chk("R10 int before drop", m_int, 1);
    m_lines = 0; tick();
    chk("R10 int after drop", m_int, 0);
    ack(v, one); chk("R10 spurious vector", v, 8'h27); chk("R10 vector driven", one, 1);
    rd(0, 0, d); chk("R10 isr unchanged", d, 8'h00);
    wr(0, 0, 8'h0A);

    // R5/R6 random patterns
    for (int it = 0; it < 30; it++) begin
      msk = 8'($urandom()) | 8'h04;
      pat = 8'($urandom()) & 8'hFB;
      if (it == 0) begin msk = 8'h04; pat = 8'h80; end
      if (it == 1) begin msk = 8'h7F; pat = 8'h7B; end
      wr(0, 1, msk);
      m_lines = pat; tick();
      exp_req = pat & ~msk;
      chk("R5 random int", m_int, int'(exp_req != 0));
      if (exp_req != 0) begin
        ack(v, one);
        chk("R6 random vector", v, 8'h20 + lowest(exp_req));
        wr(0, 0, 8'h60 + 8'(lowest(exp_req)));
      end
      m_lines = 0; tick();
    end

    // R11 cascade
    wr(0, 1, 8'h00); wr(1, 1, 8'h00);
    s_irq[3] = 1'b1; tick(); tick();
    chk("R11 master int via slave", m_int, 1);
    inta = 1'b1; #1;
    chk("R11 master select out", m_cas_sel, 1);
    chk("R11 master id out", m_cas_id, 2);
    chk("R11 master vec off", m_vec_en, 0);
    inta = 1'b0; #1;
    ack(v, one); chk("R11 slave vector", v, 8'h2B); chk("R11 single source", one, 1);
    wr(0, 0, 8'h0B); wr(1, 0, 8'h0B);
    rd(0, 0, d); chk("R11 master isr", d, 8'h04);
    rd(1, 0, d); chk("R11 slave isr", d, 8'h08);
    m_lines[0] = 1'b1; tick();
    chk("R5 IR0 over cascade", m_int, 1);
    ack(v, one); chk("R6 vector IR0", v, 8'h20);
    s_irq[1] = 1'b1; tick(); tick();
    chk("R5 cascade in service blocks", m_int, 0);
    wr(0, 0, 8'h60);
    chk("R7 still blocked by IR2", m_int, 0);
    wr(1, 0, 8'h63);
    wr(0, 0, 8'h62);
    chk("R7 eoi order releases", m_int, 1);
    ack(v, one); chk("R11 second slave vector", v, 8'h29);
    wr(1, 0, 8'h61); wr(0, 0, 8'h62);
    rd(0, 0, d); chk("R7 master isr empty", d, 8'h00);
    s_irq = 0; m_lines = 0; tick();

    // R9 auto eoi
    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
    m_lines[1] = 1'b1; tick();
    ack(v, one); chk("R9 vector", v, 8'h21);
    wr(0, 0, 8'h0B); rd(0, 0, d); chk("R9 no isr bit", d, 8'h00);
    chk("R9 no re-trigger", m_int, 0);
    m_lines = 0; tick();

    // R2 shortened sequence: single, no mode word
    wr(0, 0, 8'h12); wr(0, 1, 8'h40); wr(0, 1, 8'hFE);
    rd(0, 1, d); chk("R2 mask after short init", d, 8'hFE);
    m_lines[0] = 1'b1; tick();
    ack(v, one); chk("R2 short init base", v, 8'h40);
    m_lines = 0; tick();

    finish_run();
  end
endmodule